// File: doc/BRIEF.md
# Reset Sequencer with Source Arbitration

This block owns chip reset. It accepts a power-on reset, a watchdog expiry pulse, a clock-failure pulse and the sampled level of a bidirectional, open-drain reset pad. From these it drives the pad low, produces the internal core reset, and presents the 16-bit address the core fetches first once reset lifts. Causes that need the oscillator to restart first get a start-up delay. Every cause gets a fixed drive-low interval. The pad is then released and, after a settling window, read back. A pad that is still low means someone outside holds reset. A pad that has risen means the reset came from inside.

The sequencer is a five-state machine:
- `ST_OSC` holds the pad low during the start-up delay.
- `ST_DRIVE` holds the pad low for the drive interval.
- `ST_SETTLE` releases the pad and waits for the sample.
- `ST_EXT_WAIT` keeps the core in reset until an external holder lets go.
- `ST_RUN` is normal operation.

The transitions are:
- osc_done: `ST_OSC` to `ST_DRIVE`.
- drive_done: `ST_DRIVE` to `ST_SETTLE`.
- sample_high: `ST_SETTLE` to `ST_RUN`.
- sample_low: `ST_SETTLE` to `ST_EXT_WAIT`.
- pin_released: `ST_EXT_WAIT` to `ST_RUN`.
- pin_pulled: `ST_RUN` to `ST_DRIVE`.
- restart_osc: from any state to `ST_OSC`, taken on a clock failure, or on a watchdog expiry while in `ST_OSC`.
- restart_drive: from any other state to `ST_DRIVE`, taken on a watchdog expiry.
- power_on: an asynchronous entry into `ST_OSC`.

Two sticky flags record a clock failure and a watchdog expiry. The boot vector is chosen from these flags by fixed priority.

Top module: `rstseq_top`

## Requirements
- R1: While `por_n` is low, `core_rst_n` is low and `pin_drive_low` is high without waiting for a clock edge. Both cause flags are cleared, so the next vector is 16'hFFFE.
- R2: Take the clock cycle in which `por_n` rises as cycle 1. The pad is driven low for OSC_DELAY+DRIVE_CYC cycles, and `core_rst_n` is low for OSC_DELAY+DRIVE_CYC+SAMPLE_DLY cycles.
- R3: A `wdog_expire` pulse sets the watchdog flag. Take the cycle after the edge that samples it as cycle 1. The pad is driven low for DRIVE_CYC cycles, and `core_rst_n` is low for DRIVE_CYC+SAMPLE_DLY cycles.
- R4: A `clkfail_detect` pulse sets the clock-failure flag and uses the same counting as R3, with OSC_DELAY added to both figures. When it arrives together with `wdog_expire`, this longer path is taken.
- R5: `pin_drive_low` is never high while `core_rst_n` is high.
- R6: A low pad seen while running starts the drive interval and sets no flag. If the pad is still low when the settling window ends, both flags are cleared. `core_rst_n` then stays low through every edge that sees the pad low and rises after the first edge that sees it high.
- R7: The boot vector is 16'hFFFC when the clock-failure flag is set. Otherwise it is 16'hFFFA when the watchdog flag is set, and otherwise 16'hFFFE. Flags persist across resets that do not clear them.
- R8: A watchdog or clock-failure pulse during a sequence restarts it. A clock failure, or any cause that arrives during the start-up delay, restarts the delay. A watchdog pulse at any other point restarts the drive interval.
- R9: When a flag set and the external-reset clear fall on the same edge, the set wins.
- R10: An external pulse that ends before the sample is treated as internal, and the vector follows whatever flags are already latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| wdog_expire | input | 1 | One-cycle watchdog expiry pulse |
| clkfail_detect | input | 1 | One-cycle clock-failure pulse |
| pin_in | input | 1 | Synchronised reset pad level, 1 = high |
| pin_drive_low | output | 1 | Enables the open-drain pull-down on the pad |
| core_rst_n | output | 1 | Internal reset, active low |
| boot_vector | output | 16 | First fetch address for the core |

## Verification
After a power-on release, the core comes out of reset OSC_DELAY+DRIVE_CYC+SAMPLE_DLY cycles later. After a watchdog expiry it takes DRIVE_CYC+SAMPLE_DLY cycles, counted from the cycle after the sampling edge, and a clock failure adds OSC_DELAY to that. After a long external hold, release comes exactly as many cycles after the hold began as the hold lasted. The bench changes inputs one time unit after a rising edge and samples on falling edges. It counts, per reset episode, the low cycles of `core_rst_n` and of `pin_drive_low`. When `core_rst_n` rises, it compares both counts and the vector against the item queued for that episode.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        ST_OSC      = 3'd0,
        ST_DRIVE    = 3'd1,
        ST_SETTLE   = 3'd2,
        ST_EXT_WAIT = 3'd3,
        ST_RUN      = 3'd4
    } seq_state_e;

    localparam logic [15:0] VEC_CLKFAIL = 16'hFFFC;
    localparam logic [15:0] VEC_WDOG    = 16'hFFFA;
    localparam logic [15:0] VEC_NORMAL  = 16'hFFFE;

endpackage

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
    parameter int MAX_COUNT = 4096,
    localparam int CW = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] CNT_TOP = CW'(MAX_COUNT);

    // Saturating up-counter; a clear restarts the interval being timed.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != CNT_TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2 R3: the interval count advances by one per cycle when not cleared
    a_r2_count_step: assert property (@(posedge clk) disable iff (!por_n)
        (!clr && cnt != CNT_TOP) |=> (cnt == $past(cnt) + 1'b1));

    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!por_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/rstseq_flags.sv
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        set_cm,
    input  logic        set_cop,
    input  logic        clr,
    output logic [15:0] vector
);

    logic cm_q;
    logic cop_q;

    // Sticky cause flags; a set on the same edge as a clear wins.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cm_q  <= 1'b0;
            cop_q <= 1'b0;
        end else begin
            cm_q  <= set_cm  | (cm_q  & ~clr);
            cop_q <= set_cop | (cop_q & ~clr);
        end
    end

    always_comb begin
        if (cm_q) begin
            vector = VEC_CLKFAIL;
        end else if (cop_q) begin
            vector = VEC_WDOG;
        end else begin
            vector = VEC_NORMAL;
        end
    end

    // R9: set has priority over clear
    a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!por_n)
        (set_cop && clr) |=> cop_q);

    a_r6_clear_drops_flags: assert property (@(posedge clk) disable iff (!por_n)
        (clr && !set_cm && !set_cop) |=> (vector == VEC_NORMAL));

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int OSC_DELAY  = 4096,
    parameter int DRIVE_CYC  = 16,
    parameter int SAMPLE_DLY = 9,
    parameter int CW         = 13
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          wdog_expire,
    input  logic          clkfail_detect,
    input  logic          pin_in,
    input  logic [CW-1:0] cnt,
    output logic          tmr_clr,
    output logic          clr_flags,
    output logic          pin_drive_low,
    output logic          core_rst_n
);

    localparam logic [CW-1:0] OSC_LAST    = CW'(OSC_DELAY - 1);
    localparam logic [CW-1:0] DRIVE_LAST  = CW'(DRIVE_CYC - 1);
    localparam logic [CW-1:0] SAMPLE_LAST = CW'(SAMPLE_DLY - 1);

    seq_state_e st;
    seq_state_e nxt;
    logic       restart;

    assign restart = wdog_expire | clkfail_detect;

    // State register: power-on enters the start-up delay asynchronously.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st <= ST_OSC;
        end else begin
            st <= nxt;
        end
    end

    // Next-state logic with timer control.
    always_comb begin
        nxt       = st;
        tmr_clr   = 1'b0;
        clr_flags = 1'b0;
        unique case (st)
            ST_OSC: begin
                if (cnt == OSC_LAST) begin
                    nxt     = ST_DRIVE;
                    tmr_clr = 1'b1;
                end
            end
            ST_DRIVE: begin
                if (cnt == DRIVE_LAST) begin
                    nxt     = ST_SETTLE;
                    tmr_clr = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt == SAMPLE_LAST) begin
                    tmr_clr = 1'b1;
                    if (pin_in) begin
                        nxt = ST_RUN;
                    end else begin
                        nxt       = ST_EXT_WAIT;
                        clr_flags = 1'b1;
                    end
                end
            end
            ST_EXT_WAIT: begin
                if (pin_in) begin
                    nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (!pin_in) begin
                    nxt     = ST_DRIVE;
                    tmr_clr = 1'b1;
                end
            end
            default: begin
                nxt     = ST_OSC;
                tmr_clr = 1'b1;
            end
        endcase
        if (restart) begin
            nxt     = (clkfail_detect || st == ST_OSC) ? ST_OSC : ST_DRIVE;
            tmr_clr = 1'b1;
        end
    end

    // Output decode from the state register only.
    always_comb begin
        pin_drive_low = (st == ST_OSC) || (st == ST_DRIVE);
        core_rst_n    = (st == ST_RUN);
    end

    // R1: first edge after power-on release is still in the start-up delay
    a_r1_por_enters_delay: assert property (@(posedge clk) disable iff (!por_n)
        !$past(por_n) |-> (st == ST_OSC));

    // R3: a finished drive interval with no new cause releases the pad
    a_r3_drive_to_settle: assert property (@(posedge clk) disable iff (!por_n)
        (st == ST_DRIVE && cnt == DRIVE_LAST && !restart) |=> (st == ST_SETTLE));

    // R6: the core leaves reset only after an edge that saw the pad high
    a_r6_release_needs_high: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst_n) |-> $past(pin_in));

    // R8: a watchdog restart outside the delay lands at the drive interval
    a_r8_wdog_restart: assert property (@(posedge clk) disable iff (!por_n)
        (wdog_expire && !clkfail_detect && st != ST_OSC) |=> (st == ST_DRIVE && pin_drive_low));

    // R4: a clock failure always restarts the start-up delay
    a_r4_clkfail_restart: assert property (@(posedge clk) disable iff (!por_n)
        clkfail_detect |=> (st == ST_OSC && !core_rst_n));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int OSC_DELAY  = 4096,
    parameter int DRIVE_CYC  = 16,
    parameter int SAMPLE_DLY = 9
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        wdog_expire,
    input  logic        clkfail_detect,
    input  logic        pin_in,
    output logic        pin_drive_low,
    output logic        core_rst_n,
    output logic [15:0] boot_vector
);

    localparam int MAX_A = (OSC_DELAY > DRIVE_CYC) ? OSC_DELAY : DRIVE_CYC;
    localparam int MAXC  = (MAX_A > SAMPLE_DLY) ? MAX_A : SAMPLE_DLY;
    localparam int CW    = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic          tmr_clr;
    logic          clr_flags;

    rstseq_timer #(
        .MAX_COUNT (MAXC)
    ) u_timer (
        .clk   (clk),
        .por_n (por_n),
        .clr   (tmr_clr),
        .cnt   (cnt)
    );

    rstseq_fsm #(
        .OSC_DELAY  (OSC_DELAY),
        .DRIVE_CYC  (DRIVE_CYC),
        .SAMPLE_DLY (SAMPLE_DLY),
        .CW         (CW)
    ) u_fsm (
        .clk            (clk),
        .por_n          (por_n),
        .wdog_expire    (wdog_expire),
        .clkfail_detect (clkfail_detect),
        .pin_in         (pin_in),
        .cnt            (cnt),
        .tmr_clr        (tmr_clr),
        .clr_flags      (clr_flags),
        .pin_drive_low  (pin_drive_low),
        .core_rst_n     (core_rst_n)
    );

    rstseq_flags u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .set_cm  (clkfail_detect),
        .set_cop (wdog_expire),
        .clr     (clr_flags),
        .vector  (boot_vector)
    );

    // R5: the pad is never pulled while the core runs
    a_r5_no_drive_in_run: assert property (@(posedge clk) disable iff (!por_n)
        pin_drive_low |-> !core_rst_n);

    // R7: the vector does not move while the core runs uninterrupted
    a_r7_vector_stable: assert property (@(posedge clk) disable iff (!por_n)
        (core_rst_n && $past(core_rst_n)) |-> $stable(boot_vector));

endmodule

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int OSC_D      = 4096;
    localparam int DRV_D      = 16;
    localparam int SMP_D      = 9;

    typedef struct {
        int          low;
        int          drv;
        logic [15:0] vec;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        por_n;
    logic        wdog_expire;
    logic        clkfail_detect;
    logic        ext_hold;
    logic        pin_in;
    logic        pin_drive_low;
    logic        core_rst_n;
    logic [15:0] boot_vector;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   low_n    = 0;
    int   drv_n    = 0;
    bit   in_ep    = 1'b0;
    bit   r5_bad   = 1'b0;
    exp_t exp_q[$];
    exp_t cur;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Open-drain pad model: low if the block or the outside pulls it.
    assign pin_in = ~(pin_drive_low | ext_hold);

    rstseq_top #(
        .OSC_DELAY  (OSC_D),
        .DRIVE_CYC  (DRV_D),
        .SAMPLE_DLY (SMP_D)
    ) u_dut (
        .clk            (clk),
        .por_n          (por_n),
        .wdog_expire    (wdog_expire),
        .clkfail_detect (clkfail_detect),
        .pin_in         (pin_in),
        .pin_drive_low  (pin_drive_low),
        .core_rst_n     (core_rst_n),
        .boot_vector    (boot_vector)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int low, input int drv, input logic [15:0] vec, input string tag);
        exp_q.push_back('{low: low, drv: drv, vec: vec, tag: tag});
    endtask

    task automatic wait_run();
        do step(); while (!core_rst_n);
        repeat (3) step();
    endtask

    task automatic pulse_wdog();
        wdog_expire = 1'b1;
        step();
        wdog_expire = 1'b0;
    endtask

    task automatic hold_pin(input int cycles);
        ext_hold = 1'b1;
        repeat (cycles) step();
        ext_hold = 1'b0;
    endtask

    task automatic power_cycle(input string tag);
        por_n = 1'b0;
        repeat (3) step();
        @(negedge clk);
        check(!core_rst_n, {tag, " R1 core reset during power-on"}, core_rst_n, 0);
        check(pin_drive_low, {tag, " R1 pad pulled during power-on"}, pin_drive_low, 1);
        step();
        push(OSC_D + DRV_D + SMP_D, OSC_D + DRV_D, 16'hFFFE, {tag, " R2"});
        por_n = 1'b1;
        wait_run();
    endtask

    // Scoreboard monitor: one expected item per reset episode.
    always @(negedge clk) begin
        if (!por_n) begin
            low_n = 0;
            drv_n = 0;
            in_ep = 1'b0;
        end else if (!core_rst_n) begin
            low_n++;
            if (pin_drive_low) drv_n++;
            in_ep = 1'b1;
        end else begin
            if (pin_drive_low) r5_bad = 1'b1;
            if (in_ep) begin
                in_ep = 1'b0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected episode", low_n, 0);
                end else begin
                    cur = exp_q.pop_front();
                    check(low_n == cur.low, {cur.tag, " reset-low cycles"}, low_n, cur.low);
                    check(drv_n == cur.drv, {cur.tag, " pad-drive cycles"}, drv_n, cur.drv);
                    check(boot_vector == cur.vec, {cur.tag, " R7 vector"}, int'(boot_vector), int'(cur.vec));
                    check(!r5_bad, {cur.tag, " R5 pad pulled while running"}, int'(r5_bad), 0);
                end
                low_n = 0;
                drv_n = 0;
                r5_bad = 1'b0;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        por_n          = 1'b1;
        wdog_expire    = 1'b0;
        clkfail_detect = 1'b0;
        ext_hold       = 1'b0;
        #2;
        // R1 R2: cold start
        power_cycle("cold start");

        // R3: watchdog expiry
        push(DRV_D + SMP_D, DRV_D, 16'hFFFA, "R3 watchdog");
        pulse_wdog();
        wait_run();

        // R10: short external pulse keeps latched watchdog flag
        push(DRV_D + SMP_D, DRV_D, 16'hFFFA, "R10 short pulse");
        hold_pin(3);
        wait_run();

        // R6: long external hold clears the flags
        push(40, DRV_D, 16'hFFFE, "R6 long hold");
        hold_pin(40);
        wait_run();

        // R4: clock failure adds the start-up delay
        push(OSC_D + DRV_D + SMP_D, OSC_D + DRV_D, 16'hFFFC, "R4 clock failure");
        clkfail_detect = 1'b1;
        step();
        clkfail_detect = 1'b0;
        wait_run();

        // R7: clock-failure flag outranks a later watchdog flag
        push(DRV_D + SMP_D, DRV_D, 16'hFFFC, "R7 priority");
        pulse_wdog();
        wait_run();

        // R9: watchdog on the sample edge of an external reset
        push(50, 2 * DRV_D, 16'hFFFA, "R9 set wins");
        ext_hold = 1'b1;
        repeat (25) step();
        pulse_wdog();
        repeat (4) step();
        ext_hold = 1'b0;
        wait_run();

        // R8: second watchdog during the settling window restarts drive
        push(44, 2 * DRV_D, 16'hFFFA, "R8 restart");
        pulse_wdog();
        repeat (18) step();
        pulse_wdog();
        wait_run();

        // R4: simultaneous causes take the longer path
        push(OSC_D + DRV_D + SMP_D, OSC_D + DRV_D, 16'hFFFC, "R4 simultaneous");
        clkfail_detect = 1'b1;
        wdog_expire    = 1'b1;
        step();
        clkfail_detect = 1'b0;
        wdog_expire    = 1'b0;
        wait_run();

        // R1: power-on from running clears the flags
        power_cycle("warm power-on");

        check(exp_q.size() == 0, "all episodes seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule